// File: doc/BRIEF.md
# Byte-Wide Static Memory with Shared Tristate Data Bus

This block is a word-addressed static memory with one bidirectional 8-bit data bus and three active-low strobes: select (`sel_n`), output gate (`oeg_n`) and store (`st_n`). It is meant to stand in for a discrete byte-wide SRAM on a board-level or system model. External logic drives the bus to write. The memory drives the bus only while a read is in progress. A read is the one combination where the block is selected, the output gate is asserted and the store strobe is released.

The strobes are sampled by an internal clock, and the array behind them is synchronous. The store strobe takes priority over the output gate. While it is low, the memory keeps its drivers off, so it cannot fight the write data. While `sel_n` is high the block is in standby. In standby it neither stores nor drives, it raises a `standby` flag, and it counts the clocks spent there. The read latency in clocks is set by `RD_LAT`, which lets one build model a faster or slower speed grade.

`ADDR_W` sets the depth. The full part uses `ADDR_W = 15`, which gives 32768 words. The default is a smaller array that elaborates quickly. The bus has no valid/ready handshake, because the bus protocol is defined purely by the three strobes.

Top module: `sram_bus32k`

## Requirements
- R1: On a rising clock edge where `sel_n`=0 and `st_n`=0, the byte on `data_io` is stored at the word selected by `addr`, whatever the level of `oeg_n`.
- R2: While `sel_n`=0, `oeg_n`=0 and `st_n`=1 are held together with a steady `addr`, the stored byte at that address appears on `data_io`. It is valid after `RD_LAT` rising edges and stays valid while the condition holds.
- R3: While `sel_n`=1, the memory leaves `data_io` undriven (high impedance) in the same cycle.
- R4: While `oeg_n`=1, the memory leaves `data_io` undriven in the same cycle.
- R5: While `st_n`=0, the memory leaves `data_io` undriven even with `oeg_n`=0, and the write of R1 still happens.
- R6: A low `st_n` while `sel_n`=1 changes no stored word.
- R7: `standby` is 1 during reset. After each rising edge it equals the `sel_n` level sampled at that edge.
- R8: `idle_cnt` is 0 during reset. It adds one on every rising edge that samples `sel_n`=1, saturates at all ones, and holds on edges with `sel_n`=0.
- R9: Every address is independent, including word 0 and the highest word `2**ADDR_W-1`. Writing one word never changes another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset for the status logic |
| addr | input | ADDR_W | Word address |
| data_io | inout | DATA_W | Shared data bus, driven by the memory only during reads |
| sel_n | input | 1 | Active-low chip select |
| oeg_n | input | 1 | Active-low output gate |
| st_n | input | 1 | Active-low store strobe |
| standby | output | 1 | High while the last sampled select was inactive |
| idle_cnt | output | CNT_W | Saturating count of deselected clock edges |

## Verification
The hardest case to reach is the store strobe overriding a read while the read pipeline already holds valid data. A design with a faulty override would put that stale byte straight back on the bus. The stimulus first completes a read of a known non-all-ones word. It then drops the store strobe while keeping the output gate low, and samples the bus within the same cycle. The sampled bus must show the pull-up value rather than the stored byte. The read that follows must return the pulled value that was written, which shows the write took effect. Random traffic over a pool that includes words 0 and the top word mixes writes, reads, deselected stores and gated-off cycles. A narrow counter build makes saturation reachable within a directed standby stretch.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_READ    = 2'd1,
    OP_WRITE   = 2'd2,
    OP_STANDBY = 2'd3
  } bus_op_e;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } bus_ctl_t;

endpackage

// File: rtl/sram_op_decode.sv
`timescale 1ns/1ps
module sram_op_decode
  import sram_pkg::*;
(
  input  logic     sel_n,
  input  logic     oeg_n,
  input  logic     st_n,
  output bus_ctl_t ctl
);

  bus_op_e op;

  // Priority: deselect first, then the store strobe beats the output gate.
  always_comb begin
    if (sel_n)       op = OP_STANDBY;
    else if (!st_n)  op = OP_WRITE;
    else if (!oeg_n) op = OP_READ;
    else             op = OP_IDLE;
  end

  always_comb begin
    ctl.sel = (op != OP_STANDBY);
    ctl.wr  = (op == OP_WRITE);
    ctl.rd  = (op == OP_READ);
  end

endmodule

// File: rtl/sram_store.sv
`timescale 1ns/1ps
module sram_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [RD_LAT-1:0][DATA_W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  // Array output register followed by RD_LAT-1 delay stages.
  always_ff @(posedge clk) begin
    for (int s = RD_LAT - 1; s > 0; s--) pipe[s] <= pipe[s-1];
    if (rd_en) pipe[0] <= mem[addr];
  end

  assign rdata = pipe[RD_LAT-1];

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R5

endmodule

// File: rtl/sram_idle_track.sv
`timescale 1ns/1ps
module sram_idle_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  output logic             standby,
  output logic [CNT_W-1:0] idle_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby  <= 1'b1;
      idle_cnt <= '0;
    end else begin
      standby <= !sel;
      if (!sel && idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_SB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (standby == !$past(sel))); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && idle_cnt != CNT_MAX) |=> (idle_cnt == $past(idle_cnt) + 1'b1)); // R8

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> $stable(idle_cnt)); // R8

endmodule

// File: rtl/sram_bus32k.sv
`timescale 1ns/1ps
module sram_bus32k
  import sram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] data_io,
  input  logic              sel_n,
  input  logic              oeg_n,
  input  logic              st_n,
  output logic              standby,
  output logic [CNT_W-1:0]  idle_cnt
);

  bus_ctl_t          ctl;
  logic [DATA_W-1:0] rd_word;
  logic              drive_en;

  sram_op_decode u_dec (
    .sel_n (sel_n),
    .oeg_n (oeg_n),
    .st_n  (st_n),
    .ctl   (ctl)
  );

  sram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RD_LAT (RD_LAT)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctl.wr),
    .rd_en (ctl.rd),
    .addr  (addr),
    .wdata (data_io),
    .rdata (rd_word)
  );

  sram_idle_track #(
    .CNT_W (CNT_W)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ctl.sel),
    .standby  (standby),
    .idle_cnt (idle_cnt)
  );

  // Output drivers follow the strobes combinationally.
  assign drive_en = ctl.rd;
  assign data_io  = drive_en ? rd_word : {DATA_W{1'bz}};

  AST_HIZ_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !drive_en); // R3

  AST_HIZ_OEG: assert property (@(posedge clk) disable iff (!rst_n)
    oeg_n |-> !drive_en); // R4

  AST_STORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !st_n |-> !drive_en); // R5

  AST_NO_WR_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !ctl.wr); // R6

endmodule

// File: tb/sim_sram_bus32k.sv
`timescale 1ns/1ps
module sim_sram_bus32k;

  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int LAT = 2;
  localparam int CW  = 8;
  localparam logic [AW-1:0] TOP_ADDR = '1;
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [DW-1:0] PULLED   = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel_n = 1'b1, oeg_n = 1'b1, st_n = 1'b1;
  logic          tb_drv = 1'b0;
  logic [DW-1:0] tb_val = '0;
  logic          standby;
  logic [CW-1:0] idle_cnt;
  wire  [DW-1:0] bus;
  logic          done = 1'b0;

  assign bus = tb_drv ? tb_val : {DW{1'bz}};
  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup (bus[i]);
  end

  always #4 clk = ~clk;

  sram_bus32k #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_io(bus),
    .sel_n(sel_n), .oeg_n(oeg_n), .st_n(st_n),
    .standby(standby), .idle_cnt(idle_cnt)
  );

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] shadow [int];
  logic [AW-1:0] pool [16];

  // Expected status from R7/R8
  logic          exp_sb = 1'b1;
  logic [CW-1:0] exp_idle = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_sb   <= 1'b1;
      exp_idle <= '0;
    end else begin
      exp_sb <= sel_n;
      if (sel_n && exp_idle != CNT_MAX) exp_idle <= exp_idle + 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      check("R7 standby", {31'd0, standby}, {31'd0, exp_sb});
      check("R8 idle_cnt", {24'd0, idle_cnt}, {24'd0, exp_idle});
    end
  end

  function automatic logic [DW-1:0] pick_data();
    return DW'($urandom % 255);  // never all ones, so the pull-up is distinguishable
  endfunction

  task automatic release_bus();
    sel_n = 1'b1; oeg_n = 1'b1; st_n = 1'b1; tb_drv = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; sel_n = 1'b0; st_n = 1'b0; oeg_n = 1'($urandom % 2);
    tb_drv = 1'b1; tb_val = d;
    @(negedge clk);
    shadow[int'(a)] = d;
    release_bus();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    addr = a; sel_n = 1'b0; oeg_n = 1'b0; st_n = 1'b1; tb_drv = 1'b0;
    repeat (LAT) @(negedge clk);
    #1;
    if (shadow.exists(int'(a))) check(req, {24'd0, bus}, {24'd0, shadow[int'(a)]});
    release_bus();
  endtask

  task automatic hiz_check(input logic s, input logic o, input logic [AW-1:0] a, input string req);
    @(negedge clk);
    addr = a; sel_n = s; oeg_n = o; st_n = 1'b1; tb_drv = 1'b0;
    repeat (LAT) @(negedge clk);
    #1;
    check(req, {24'd0, bus}, {24'd0, PULLED});
    release_bus();
  endtask

  task automatic desel_store(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; sel_n = 1'b1; st_n = 1'b0; oeg_n = 1'b0;
    tb_drv = 1'b1; tb_val = pick_data();
    @(negedge clk);
    release_bus();
  endtask

  initial begin
    void'($urandom(32'd2024));
    pool[0] = '0;
    pool[1] = TOP_ADDR;
    for (int i = 2; i < 16; i++) pool[i] = AW'($urandom);

    // Reset state
    repeat (3) @(negedge clk);
    check("R7 reset standby", {31'd0, standby}, 32'd1);
    check("R8 reset idle_cnt", {24'd0, idle_cnt}, 32'd0);
    check("R3 reset bus", {24'd0, bus}, {24'd0, PULLED});
    rst_n = 1'b1;

    // Directed: boundary words (R9) and read-back (R1, R2)
    do_write('0, 8'h5A);
    do_write(TOP_ADDR, 8'hA5);
    do_write(AW'(1), 8'h3C);
    do_read('0, "R9 word0");
    do_read(TOP_ADDR, "R9 top word");
    do_read(AW'(1), "R1 R2 readback");

    // R3 / R4 directed
    hiz_check(1'b1, 1'b0, '0, "R3 deselected");
    hiz_check(1'b0, 1'b1, '0, "R4 gate off");

    // R5: loaded read, then store strobe drops with gate still low
    @(negedge clk);
    addr = AW'(1); sel_n = 1'b0; oeg_n = 1'b0; st_n = 1'b1; tb_drv = 1'b0;
    repeat (LAT) @(negedge clk);
    #1 check("R2 before override", {24'd0, bus}, 32'h3C);
    st_n = 1'b0;
    #1 check("R5 store overrides gate", {24'd0, bus}, {24'd0, PULLED});
    @(negedge clk);
    shadow[1] = PULLED;
    release_bus();
    do_read(AW'(1), "R5 override write landed");

    // R6 directed
    desel_store('0);
    do_read('0, "R6 deselected store ignored");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      automatic logic [AW-1:0] a = pool[$urandom % 16];
      case ($urandom % 5)
        0: do_write(a, pick_data());
        1: do_read(a, "R2 R9 random read");
        2: begin desel_store(a); do_read(a, "R6 random deselected store"); end
        3: hiz_check(1'b0, 1'b1, a, "R4 random gate off");
        default: hiz_check(1'b1, 1'($urandom % 2), a, "R3 random deselect");
      endcase
    end

    // R8 saturation
    @(negedge clk);
    release_bus();
    repeat (300) @(negedge clk);
    #1 check("R8 saturated", {24'd0, idle_cnt}, {24'd0, CNT_MAX});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule